// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This block keeps, for each of up to four processors, one pending bit for an inter-processor interrupt (IPI) and one pending bit for an interval-timer interrupt. Each pending bit drives that processor's interrupt line directly. IPI lines and timer lines are separate outputs so that the interrupt fabric can give them different priority levels. Both are also separate from any device interrupt line.

Software reaches the block through a small register port. A control register packs an IPI request mask, an IPI clear mask and a timer clear mask into one write word, and all three act in the same cycle. Three more registers each take one full per-processor mask: IPI clear, timer clear and IPI request. A tick input from an external interval timer marks a timer interrupt as pending on every processor. A read of the control register returns both pending vectors and the number of the processor that issued the read.

Writes that change nothing are reported on a one-cycle flag. These are a request for an IPI that is already pending, or a clear of an IPI that is not pending. A control write that carries no operation at all raises a separate error pulse.

Top module: `ipi_tmr_unit`

## Requirements
- R1: After reset both pending vectors are zero, and `ipi_irq`, `tmr_irq`, `redundant`, `cfg_err` and `rvalid` are all low.
- R2: A write to the control register (addr 0) sets IPI pending for CPU k when data bit 12+k is 1. The matching `ipi_irq` bit is high from the cycle after the write.
- R3: A write to the control register clears IPI pending for CPU k when data bit 8+k is 1.
- R4: A write to the control register clears timer pending for CPU k when data bit 4+k is 1.
- R5: When one write both requests and clears the IPI of the same CPU, the IPI ends up pending.
- R6: A control write with only bit 28 set, the memory-error acknowledge, changes no pending state and raises neither `cfg_err` nor `redundant`.
- R7: A control write with bits 15:4 all zero and bit 28 clear pulses `cfg_err` for one cycle and changes no state.
- R8: `redundant` pulses for one cycle after a write that requests an IPI that is already pending. It also pulses after a write that clears a pending-free IPI that the same write does not request. No state changes for those bits.
- R9: A `tick` cycle sets timer pending on every CPU. If a timer clear arrives in the same cycle, the tick wins.
- R10: Writes to addr 1, addr 2 and addr 3 take a per-CPU mask in data bits NCPU-1:0. Addr 1 clears IPIs, addr 2 clears timer interrupts and addr 3 requests IPIs.
- R11: A read returns data with `rvalid` one cycle after `rd_en`, and the data shows the state before any write in the same cycle. For addr 0 the data is: IPI pending in bits 8+k, timer pending in bits 4+k, and `cpu_id` in bits 1:0. Addr 1 and addr 3 return the IPI pending vector and addr 2 returns the timer pending vector, each in the low bits.
- R12: `ipi_irq` and `tmr_irq` always equal the IPI and timer pending vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register index: 0 control, 1 IPI clear, 2 timer clear, 3 IPI request |
| wdata | input | DW | Write data |
| cpu_id | input | CW | Number of the processor issuing the access |
| tick | input | 1 | Interval timer tick |
| rdata | output | DW | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| ipi_irq | output | NCPU | Per-CPU IPI lines |
| tmr_irq | output | NCPU | Per-CPU timer interrupt lines |
| redundant | output | 1 | Pulse: a write requested or cleared an IPI with no effect |
| cfg_err | output | 1 | Pulse: a control write carried no operation |

## Verification
The hardest situations to reach are the ones where several updates land in the same cycle. These are a request and a clear for one CPU in one control write, a tick together with a timer clear, and a read issued in the same cycle as a write that changes what the read returns. The stimulus builds these cases on purpose. First it drives the pending vectors to mixed patterns, for example with odd-numbered CPUs pending. Then it issues the combined operations in single cycles. A behavioural model computes every output per bit and compares on each clock. The redundancy flag is reached by repeating requests and clears against states that are known to be pending and known to be clear.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_IPI_CLR = 2'd1,
        REG_TMR_CLR = 2'd2,
        REG_IPI_SET = 2'd3
    } reg_idx_e;

    localparam int CTRL_REQ_LSB  = 12;
    localparam int CTRL_CLR_LSB  = 8;
    localparam int CTRL_TCLR_LSB = 4;
    localparam int CTRL_ACK_BIT  = 28;
    localparam int CTRL_OPS_MSB  = 15;
endpackage

// File: rtl/ipi_tmr_decode.sv
module ipi_tmr_decode
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int DW   = 64
) (
    input  logic            wr_en_i,
    input  logic [1:0]      addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [NCPU-1:0] set_o,
    output logic [NCPU-1:0] clr_o,
    output logic [NCPU-1:0] tclr_o,
    output logic            err_o
);
    always_comb begin
        set_o  = '0;
        clr_o  = '0;
        tclr_o = '0;
        err_o  = 1'b0;
        if (wr_en_i) begin
            unique case (reg_idx_e'(addr_i))
                REG_CTRL: begin
                    set_o  = wdata_i[CTRL_REQ_LSB  +: NCPU];
                    clr_o  = wdata_i[CTRL_CLR_LSB  +: NCPU];
                    tclr_o = wdata_i[CTRL_TCLR_LSB +: NCPU];
                    err_o  = (wdata_i[CTRL_OPS_MSB:CTRL_TCLR_LSB] == '0)
                             && !wdata_i[CTRL_ACK_BIT];
                end
                REG_IPI_CLR: clr_o  = wdata_i[NCPU-1:0];
                REG_TMR_CLR: tclr_o = wdata_i[NCPU-1:0];
                REG_IPI_SET: set_o  = wdata_i[NCPU-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ipi_tmr_pend.sv
module ipi_tmr_pend #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCPU-1:0] set_i,
    input  logic [NCPU-1:0] clr_i,
    input  logic [NCPU-1:0] tclr_i,
    input  logic            tick_i,
    output logic [NCPU-1:0] ipi_o,
    output logic [NCPU-1:0] tmr_o,
    output logic            redund_o
);
    typedef struct packed {
        logic [NCPU-1:0] ipi;
        logic [NCPU-1:0] tmr;
        logic            redund;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.ipi    = (st_q.ipi & ~clr_i) | set_i;
        st_d.tmr    = tick_i ? '1 : (st_q.tmr & ~tclr_i);
        st_d.redund = (|(set_i & st_q.ipi)) || (|(clr_i & ~st_q.ipi & ~set_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ipi_o    = st_q.ipi;
    assign tmr_o    = st_q.tmr;
    assign redund_o = st_q.redund;

    AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((ipi_o & $past(set_i)) == $past(set_i))); // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((ipi_o & $past(clr_i & ~set_i)) == '0)); // R3
    AST_TICK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (&tmr_o)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && set_i == '0 && clr_i == '0 && tclr_i == '0)
        |=> ($stable(ipi_o) && $stable(tmr_o) && !redund_o)); // R7
endmodule

// File: rtl/ipi_tmr_unit.sv
module ipi_tmr_unit
    import ipi_tmr_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int DW   = 64,
    localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic [CW-1:0]   cpu_id,
    input  logic            tick,
    output logic [DW-1:0]   rdata,
    output logic            rvalid,
    output logic [NCPU-1:0] ipi_irq,
    output logic [NCPU-1:0] tmr_irq,
    output logic            redundant,
    output logic            cfg_err
);
    logic [NCPU-1:0] set_m, clr_m, tclr_m;
    logic            err_c;

    ipi_tmr_decode #(.NCPU(NCPU), .DW(DW)) u_dec (
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .set_o   (set_m),
        .clr_o   (clr_m),
        .tclr_o  (tclr_m),
        .err_o   (err_c)
    );

    ipi_tmr_pend #(.NCPU(NCPU)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_m),
        .clr_i    (clr_m),
        .tclr_i   (tclr_m),
        .tick_i   (tick),
        .ipi_o    (ipi_irq),
        .tmr_o    (tmr_irq),
        .redund_o (redundant)
    );

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
        logic          err;
    } port_t;

    port_t pt_d, pt_q;

    always_comb begin
        pt_d        = '0;
        pt_d.err    = err_c;
        pt_d.rvalid = rd_en;
        if (rd_en) begin
            unique case (reg_idx_e'(addr))
                REG_CTRL: begin
                    pt_d.rdata[CTRL_CLR_LSB  +: NCPU] = ipi_irq;
                    pt_d.rdata[CTRL_TCLR_LSB +: NCPU] = tmr_irq;
                    pt_d.rdata[CW-1:0]                = cpu_id;
                end
                REG_TMR_CLR: pt_d.rdata[NCPU-1:0] = tmr_irq;
                default:     pt_d.rdata[NCPU-1:0] = ipi_irq;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign rdata   = pt_q.rdata;
    assign rvalid  = pt_q.rvalid;
    assign cfg_err = pt_q.err;

    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($past(wr_en) && $past(addr) == REG_CTRL)); // R7
    AST_RVALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R11
    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_c && !tick) |=> ($stable(ipi_irq) && $stable(tmr_irq))); // R7
endmodule

// File: tb/tb_ipi_tmr_unit.sv
module tb_ipi_tmr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int DW   = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [1:0]      addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [1:0]      cpu_id = '0;
    logic [DW-1:0]   rdata;
    logic            rvalid, redundant, cfg_err;
    logic [NCPU-1:0] ipi_irq, tmr_irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    logic [3:0] m_ipi = '0, m_tmr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_tmr_unit #(.NCPU(NCPU), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .cpu_id(cpu_id), .tick(tick), .rdata(rdata),
        .rvalid(rvalid), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .redundant(redundant), .cfg_err(cfg_err)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(bit we, bit re, logic [1:0] a, logic [63:0] d,
                        logic [1:0] cid, bit tk, string tag);
        logic [3:0] s, c, tc, n_ipi, n_tmr;
        bit e_red, e_err;
        logic [63:0] e_rd;
        s = '0; c = '0; tc = '0; e_err = 0; e_red = 0; e_rd = '0;
        if (we) begin
            case (a)
                2'd0: begin
                    s = d[15:12]; c = d[11:8]; tc = d[7:4];
                    e_err = (d[15:4] == 0) && !d[28];
                end
                2'd1: c  = d[3:0];
                2'd2: tc = d[3:0];
                default: s = d[3:0];
            endcase
        end
        for (int k = 0; k < NCPU; k++) begin
            if (s[k] && m_ipi[k]) e_red = 1;
            if (c[k] && !m_ipi[k] && !s[k]) e_red = 1;
            n_ipi[k] = s[k] ? 1'b1 : (c[k] ? 1'b0 : m_ipi[k]);
            n_tmr[k] = tk ? 1'b1 : (tc[k] ? 1'b0 : m_tmr[k]);
        end
        if (re) begin
            case (a)
                2'd0: e_rd = {52'd0, m_ipi, m_tmr, 2'b00, cid};
                2'd2: e_rd = {60'd0, m_tmr};
                default: e_rd = {60'd0, m_ipi};
            endcase
        end
        wr_en = we; rd_en = re; addr = a; wdata = d; cpu_id = cid; tick = tk;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; tick = 0;
        m_ipi = n_ipi; m_tmr = n_tmr;
        chk({tag, " ipi_irq R12"}, 64'(ipi_irq), 64'(m_ipi));
        chk({tag, " tmr_irq R12"}, 64'(tmr_irq), 64'(m_tmr));
        chk({tag, " redundant R8"}, 64'(redundant), 64'(e_red));
        chk({tag, " cfg_err R7"}, 64'(cfg_err), 64'(e_err));
        chk({tag, " rvalid R11"}, 64'(rvalid), 64'(re));
        if (re) chk({tag, " rdata R11"}, rdata, e_rd);
    endtask

    initial begin
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("reset ipi R1", 64'(ipi_irq), 0);
        chk("reset tmr R1", 64'(tmr_irq), 0);
        chk("reset flags R1", {61'd0, redundant, cfg_err, rvalid}, 0);
        rst_n = 1;
        @(negedge clk);
        step(1, 0, 0, 64'h5000, 0, 0, "R2 request 0101");
        step(1, 0, 0, 64'h1000, 0, 0, "R8 re-request cpu0");
        step(1, 0, 0, 64'h0100, 0, 0, "R3 clear cpu0");
        step(1, 0, 0, 64'h0200, 0, 0, "R8 clear idle cpu1");
        step(1, 0, 0, 64'h2200, 0, 0, "R5 req+clr cpu1");
        step(0, 1, 0, 64'h0, 2, 0, "R11 read ctrl cpu2");
        step(0, 0, 0, 64'h0, 0, 1, "R9 tick");
        step(1, 0, 0, 64'h0030, 0, 0, "R4 ctrl timer clear");
        step(0, 1, 2, 64'h0, 1, 0, "R11 read timer");
        step(1, 0, 2, 64'h000F, 0, 1, "R9 tick beats clear");
        step(1, 0, 0, 64'h1000_0000, 0, 0, "R6 ack only");
        step(1, 0, 0, 64'h0000_0003, 0, 0, "R7 empty write");
        step(1, 0, 1, 64'h000F, 0, 0, "R10 ipi clear reg");
        step(1, 0, 3, 64'h0009, 0, 0, "R10 ipi set reg");
        step(1, 0, 2, 64'h0006, 0, 0, "R10 timer clear reg");
        step(0, 1, 1, 64'h0, 0, 0, "R11 read ipi");
        step(1, 1, 0, 64'hF000, 3, 0, "R11 read with write");
        step(0, 1, 3, 64'h0, 0, 0, "R11 read addr3");
        step(1, 0, 0, 64'h0FF0, 0, 0, "R3 R4 clear all");
        for (int i = 0; i < 16; i++)
            step(1, (i % 3) == 0, 0, 64'(i) << 12 | 64'(15 - i) << 8, 2'(i), (i % 5) == 0, "R2 R3 sweep");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule